// File: doc/BRIEF.md
# E1 Performance Error Counter Bank

This block counts performance-monitoring events for an E1 receive path and keeps a stable snapshot of every count for the host to read. Five full-width counters track code violations, framing bit errors, CRC errors, far-end CRC error reports carried in the E bits, and CRC error events reported through the spare-bit patterns. A sixth counter word is split into two narrow fields: multiframes received while out of alignment, and changes of frame alignment. Each event arrives as a single-cycle pulse from detection logic upstream.

Every counter has a hold register. A snapshot copies all counters into their hold registers in one edge and restarts the counters. Snapshots come either from a one-second tick or from a host write strobe, which runs a short busy/done handshake. Counters stop at their maximum value rather than wrapping. An event that lands in the same cycle as a snapshot is carried into the new counting period.

Top module: `err_cnt_bank`

## Requirements
- R1: After reset every hold word reads 0, and `busy_o` and `done_o` are low.
- R2: Each `ev_full_i[k]` pulse adds one to full counter k: k=0 code violation, k=1 framing bit error, k=2 CRC error, k=3 far-end CRC error, k=4 spare-bit CRC event. Hold word k sits at `hold_o[16k+15:16k]`.
- R3: A full counter that reaches 65535 stays at 65535 on further events until it is restarted.
- R4: Hold word 5 holds the out-of-alignment multiframe count in bits 5:0 and the alignment-change count in bits 7:6, with bits 15:8 zero. The two fields saturate independently, at 63 and at 3.
- R5: With `on_demand_i` low, a `sec_tick_i` pulse loads every hold word at that clock edge, so the new values are visible in the next cycle, and it restarts all counters. Hold words change at no other time in this mode.
- R6: An event in the same cycle as a snapshot is not counted in that snapshot. Its counter restarts at 1 instead of 0.
- R7: With `on_demand_i` high, a `snap_req_i` pulse while idle raises `busy_o` in the next cycle. The snapshot is taken at the end of that cycle. In the following cycle `busy_o` and `done_o` are both high, and in the cycle after that both are low.
- R8: `sec_tick_i` has no effect while `on_demand_i` is high. `snap_req_i` has no effect while `on_demand_i` is low.
- R9: A `snap_req_i` pulse that arrives while `busy_o` is high is dropped. It neither extends the handshake nor causes a second snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_demand_i | input | 1 | 0: snapshot on the second tick; 1: snapshot on host request |
| sec_tick_i | input | 1 | One-second tick pulse |
| snap_req_i | input | 1 | Host snapshot request strobe |
| ev_full_i | input | 5 | Event pulses for the five full counters |
| ev_mf_async_i | input | 1 | Multiframe received while out of alignment |
| ev_cofa_i | input | 1 | Change of frame alignment |
| hold_o | output | 96 | Six 16-bit hold words, word k at bits 16k+15:16k |
| busy_o | output | 1 | On-demand snapshot in progress |
| done_o | output | 1 | Snapshot complete, high in the last busy cycle |

## Verification
The bench drives an event on the same edge as a tick and again in the load cycle of a request. A design that cleared the counter without adding that event would read 0 where 1 is expected in the next snapshot. It pushes the narrow fields past 63 and 3, and one full counter past 65535. A wrapping design would show small residues, and a shared carry would spill into the neighbouring field or into the upper byte. It also sends ticks in request mode, requests in tick mode, and a request during busy. Any of these that was wrongly accepted would change a hold word or stretch `busy_o`.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;

  typedef enum logic [1:0] {
    SNAP_IDLE = 2'd0,
    SNAP_LOAD = 2'd1,
    SNAP_DONE = 2'd2
  } snap_state_e;

endpackage

// File: rtl/ecb_sat_cnt.sv
module ecb_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      // coincident event opens the new period
      cnt_q <= W'(inc_i);
    end else if (inc_i && (cnt_q != MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ecb_split_cnt.sv
module ecb_split_cnt #(
  parameter int CNT_W  = 16,
  parameter int MF_W   = 6,
  parameter int COFA_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mf_i,
  input  logic             cofa_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] word_o
);

  logic [MF_W-1:0]   mf_cnt;
  logic [COFA_W-1:0] cofa_cnt;

  ecb_sat_cnt #(.W(MF_W)) u_mf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (mf_i),
    .restart_i(restart_i),
    .cnt_o    (mf_cnt)
  );

  ecb_sat_cnt #(.W(COFA_W)) u_cofa (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (cofa_i),
    .restart_i(restart_i),
    .cnt_o    (cofa_cnt)
  );

  assign word_o = CNT_W'({cofa_cnt, mf_cnt});

endmodule

// File: rtl/ecb_snap_ctrl.sv
module ecb_snap_ctrl
  import err_cnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_demand_i,
  input  logic sec_tick_i,
  input  logic req_i,
  output logic snap_o,
  output logic busy_o,
  output logic done_o
);

  snap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SNAP_IDLE: if (on_demand_i && req_i) state_d = SNAP_LOAD;
      SNAP_LOAD: state_d = SNAP_DONE;
      SNAP_DONE: state_d = SNAP_IDLE;
      default:   state_d = SNAP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SNAP_IDLE;
    else         state_q <= state_d;
  end

  assign snap_o = (!on_demand_i && sec_tick_i) || (state_q == SNAP_LOAD);
  assign busy_o = (state_q != SNAP_IDLE);
  assign done_o = (state_q == SNAP_DONE);

endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank #(
  parameter int CNT_W    = 16,
  parameter int NUM_FULL = 5,
  parameter int MF_W     = 6,
  parameter int COFA_W   = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           on_demand_i,
  input  logic                           sec_tick_i,
  input  logic                           snap_req_i,
  input  logic [NUM_FULL-1:0]            ev_full_i,
  input  logic                           ev_mf_async_i,
  input  logic                           ev_cofa_i,
  output logic [(NUM_FULL+1)*CNT_W-1:0]  hold_o,
  output logic                           busy_o,
  output logic                           done_o
);

  localparam int NUM_CNT = NUM_FULL + 1;
  localparam int SPLIT_IDX = NUM_FULL;

  logic             snap;
  logic [CNT_W-1:0] cnt_w  [NUM_CNT];
  logic [CNT_W-1:0] hold_q [NUM_CNT];

  ecb_snap_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .on_demand_i(on_demand_i),
    .sec_tick_i (sec_tick_i),
    .req_i      (snap_req_i),
    .snap_o     (snap),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  for (genvar k = 0; k < NUM_FULL; k++) begin : g_full
    ecb_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (ev_full_i[k]),
      .restart_i(snap),
      .cnt_o    (cnt_w[k])
    );
  end

  ecb_split_cnt #(
    .CNT_W (CNT_W),
    .MF_W  (MF_W),
    .COFA_W(COFA_W)
  ) u_split (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mf_i     (ev_mf_async_i),
    .cofa_i   (ev_cofa_i),
    .restart_i(snap),
    .word_o   (cnt_w[SPLIT_IDX])
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   hold_q[k] <= '0;
      else if (snap) hold_q[k] <= cnt_w[k];
    end
    assign hold_o[k*CNT_W +: CNT_W] = hold_q[k];
  end

endmodule

// File: rtl/err_cnt_bank_chk.sv
module err_cnt_bank_chk #(
  parameter int CNT_W    = 16,
  parameter int NUM_FULL = 5
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          on_demand_i,
  input logic                          sec_tick_i,
  input logic                          snap_req_i,
  input logic [(NUM_FULL+1)*CNT_W-1:0] hold_o,
  input logic                          busy_o,
  input logic                          done_o
);

  a_r7_busy_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && on_demand_i && snap_req_i) |=> (busy_o && !done_o));

  a_r7_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r7_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> done_o);

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));

  a_r8_tick_mode_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_demand_i && !busy_o) |=> !busy_o);

  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(!on_demand_i && sec_tick_i) && !(busy_o && !done_o)) |=> $stable(hold_o));

endmodule

bind err_cnt_bank err_cnt_bank_chk #(
  .CNT_W   (CNT_W),
  .NUM_FULL(NUM_FULL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .on_demand_i(on_demand_i),
  .sec_tick_i (sec_tick_i),
  .snap_req_i (snap_req_i),
  .hold_o     (hold_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/err_cnt_bank_bench.sv
`timescale 1ns/1ps
module err_cnt_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic [4:0]  ev = '0;
  logic        mf = 1'b0;
  logic        cofa = 1'b0;
  logic [95:0] hold;
  logic        busy, done;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_cnt [5];
  int m_mf, m_cofa;
  int m_hold [6];
  int m_st;

  always #2.5 clk = ~clk;

  err_cnt_bank u_err_cnt_bank (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .on_demand_i  (mode),
    .sec_tick_i   (tick),
    .snap_req_i   (req),
    .ev_full_i    (ev),
    .ev_mf_async_i(mf),
    .ev_cofa_i    (cofa),
    .hold_o       (hold),
    .busy_o       (busy),
    .done_o       (done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int word(input int k);
    return int'(hold[k*16 +: 16]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      foreach (m_hold[i]) m_hold[i] = 0;
      m_mf = 0; m_cofa = 0; m_st = 0;
    end else begin
      bit snap;
      snap = (!mode && tick) || (m_st == 1);
      if (snap) begin
        for (int i = 0; i < 5; i++) begin
          m_hold[i] = m_cnt[i];
          m_cnt[i] = ev[i] ? 1 : 0;
        end
        m_hold[5] = m_cofa * 64 + m_mf;
        m_mf = mf ? 1 : 0;
        m_cofa = cofa ? 1 : 0;
      end else begin
        for (int i = 0; i < 5; i++)
          if (ev[i] && m_cnt[i] < 65535) m_cnt[i]++;
        if (mf && m_mf < 63) m_mf++;
        if (cofa && m_cofa < 3) m_cofa++;
      end
      case (m_st)
        0: if (mode && req) m_st = 1;
        1: m_st = 2;
        default: m_st = 0;
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 5; i++) chk("R2 model word", word(i), m_hold[i]);
      chk("R4 model split word", word(5), m_hold[5]);
      chk("R7 model busy", int'(busy), (m_st != 0) ? 1 : 0);
      chk("R7 model done", int'(done), (m_st == 2) ? 1 : 0);
    end
  end

  task automatic drive(input logic [4:0] e, input logic m, input logic c,
                       input logic t, input logic r);
    ev = e; mf = m; cofa = c; tick = t; req = r;
    @(negedge clk);
    ev = '0; mf = 1'b0; cofa = 1'b0; tick = 1'b0; req = 1'b0;
  endtask

  task automatic idle();
    drive(5'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) chk("R1 reset hold word", word(i), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R4 / R5: mixed pattern then tick
    drive(5'b11111, 1'b1, 1'b1, 1'b0, 1'b0);
    drive(5'b00011, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(5'b00011, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(5'b00001, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 hold before tick", word(0), 0);
    drive(5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 code violation", word(0), 4);
    chk("R2 framing", word(1), 3);
    chk("R2 crc", word(2), 1);
    chk("R2 far-end crc", word(3), 1);
    chk("R2 spare-bit crc", word(4), 1);
    chk("R4 split fields", word(5), 67);

    // R6: event on the tick edge
    drive(5'b00001, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 snapshot excludes coincident event", word(0), 0);
    idle(); idle();
    drive(5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 restart at one", word(0), 1);

    // R4: independent field saturation
    repeat (70) drive(5'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (5)  drive(5'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 fields saturate", word(5), 255);

    // R3: full counter saturation
    repeat (65540) drive(5'b00001, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 saturate at max", word(0), 65535);
    chk("R3 neighbour untouched", word(1), 0);

    // R7: on-demand handshake with event in load cycle
    mode = 1'b1;
    drive(5'b00100, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(5'b00100, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(5'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 busy after req", int'(busy), 1);
    chk("R7 no done yet", int'(done), 0);
    chk("R7 hold not yet loaded", word(2), 0);
    drive(5'b00100, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 done cycle busy", int'(busy), 1);
    chk("R7 done cycle done", int'(done), 1);
    chk("R7 hold loaded", word(2), 2);
    idle();
    chk("R7 busy released", int'(busy), 0);

    // R8: ignored inputs per mode
    drive(5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 tick ignored on demand", word(2), 2);
    mode = 1'b0;
    drive(5'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 req ignored in tick mode", int'(busy), 0);
    chk("R8 hold unchanged", word(2), 2);
    drive(5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 load-cycle event carried", word(2), 1);

    // R9: request while busy
    mode = 1'b1;
    drive(5'b00010, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(5'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 done on schedule", int'(done), 1);
    chk("R9 hold loaded", word(1), 1);
    drive(5'b00010, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 busy not extended", int'(busy), 0);
    idle();
    chk("R9 no second handshake", int'(busy), 0);
    chk("R9 no second snapshot", word(1), 1);

    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule